// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Filtering

This block receives 9-bit asynchronous serial frames on a shared multidrop line. It decides for each frame whether the local processor should be interrupted. A frame has a low start bit, eight data bits sent least significant bit first, a ninth bit, and a high stop bit. Frames whose ninth bit is 1 carry an address. Frames whose ninth bit is 0 carry data.

Software supplies three settings: a station address, an address mask and a filter-enable bit. With the filter enabled, the block interrupts only on address frames that hit one of two targets. The first is the station address, compared only at the positions where the mask holds 1. The second is a group address formed as the bitwise OR of the station address and the mask: every 1 in it must also be 1 in the received byte. With the filter disabled, every well-formed frame interrupts. A slave clears the filter bit once it has been selected, so that it receives the data frames that follow. The line is oversampled 16 times per bit. The oversampling tick comes from the system clock through a simple divider.

Top module: `mpuart_addr_filter`

## Requirements
- R1: One bit time is 16 × TICK_DIV clock cycles. After a falling edge, the start bit is confirmed low at mid-bit. A low pulse shorter than half a bit time starts no frame. Each of the nine data bits is sampled near the centre of its bit, and data arrives LSB first.
- R2: A frame whose stop bit samples 0 raises no interrupt and leaves rxByte and rxNinth unchanged. The receiver then waits for the line to go high before it looks for the next start bit.
- R3: With filterEn = 0, every frame with a good stop bit sets rxIntFlag. Such a frame also loads rxByte with its eight data bits and rxNinth with its ninth bit, whatever the ninth bit is.
- R4: With filterEn = 1, a frame whose ninth bit is 0 is discarded.
- R5: With filterEn = 1, an address frame (ninth bit 1) whose data byte d satisfies ((d XOR stationAddr) AND addrMask) = 0 is accepted.
- R6: With filterEn = 1, an address frame whose byte d satisfies (d AND g) = g, where g = stationAddr OR addrMask, is accepted. The byte 0xFF therefore always qualifies.
- R7: With filterEn = 1, an address frame that meets neither R5 nor R6 is discarded.
- R8: A discarded frame changes neither rxByte, rxNinth nor rxIntFlag.
- R9: rxIntFlag stays set until a one-cycle intClear pulse. That pulse clears both rxIntFlag and overrun.
- R10: If a frame is accepted while rxIntFlag is already set and no clear arrives in that cycle, overrun becomes 1. The new frame still overwrites rxByte and rxNinth.
- R11: After reset, rxIntFlag, overrun, rxByte and rxNinth are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Serial receive line, idle high |
| filterEn | input | 1 | Enables address filtering |
| stationAddr | input | 8 | Station address |
| addrMask | input | 8 | Compare mask; 1 means the bit is checked |
| intClear | input | 1 | One-cycle pulse that clears the flag and overrun |
| rxByte | output | 8 | Data bits of the last accepted frame |
| rxNinth | output | 1 | Ninth bit of the last accepted frame |
| rxIntFlag | output | 1 | Receive interrupt flag |
| overrun | output | 1 | An accepted frame arrived while the flag was set |

## Verification
The assertions judge each frame with the station address, mask and filter bit that are present when the stop bit is sampled. They therefore assume software changes these settings only while the line is idle. The stimulus follows that rule: it applies new settings and waits at least one bit time of idle before each frame. The assertions also assume intClear is a single-cycle pulse that is not tied high. The bench drives it only between frames, except in the overrun case, where it is deliberately withheld.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
  typedef struct packed {
    logic shift;    // sample one bit into the shift register
    logic frameOk;  // stop bit sampled high, frame complete
  } rxStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_STOP, S_BREAK
  } rxState_t;
endpackage

// File: rtl/mpuart_ctrl.sv
module mpuart_ctrl
  import mpuart_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int OVS      = 16,
  parameter int TICK_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxSync,
  output rxStrobe_t  strb
);
  localparam int NBITS = DATA_W + 1;
  localparam int CNT_W = $clog2(OVS);
  localparam int DIV_W = $clog2(TICK_DIV) + 1;
  localparam int IDX_W = $clog2(NBITS + 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  rxState_t         state;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] smpCnt;
  logic [IDX_W-1:0] bitCnt;
  logic             tick;

  assign tick = (divCnt == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      divCnt <= '0;
      smpCnt <= '0;
      bitCnt <= '0;
    end else begin
      if (state == S_IDLE) divCnt <= '0;
      else                 divCnt <= tick ? '0 : divCnt + 1'b1;
      case (state)
        S_IDLE: if (!rxSync) begin
          state  <= S_START;
          smpCnt <= '0;
        end
        S_START: if (tick) begin
          if (smpCnt == MID) begin
            smpCnt <= '0;
            bitCnt <= '0;
            state  <= rxSync ? S_IDLE : S_DATA;
          end else smpCnt <= smpCnt + 1'b1;
        end
        S_DATA: if (tick) begin
          if (smpCnt == LAST) begin
            smpCnt <= '0;
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == IDX_W'(NBITS - 1)) state <= S_STOP;
          end else smpCnt <= smpCnt + 1'b1;
        end
        S_STOP: if (tick) begin
          if (smpCnt == LAST) state <= rxSync ? S_IDLE : S_BREAK;
          else                smpCnt <= smpCnt + 1'b1;
        end
        S_BREAK: if (rxSync) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.shift   = (state == S_DATA) && tick && (smpCnt == LAST);
    strb.frameOk = (state == S_STOP) && tick && (smpCnt == LAST) && rxSync;
  end

  // R1: a completed frame has shifted in exactly nine bits
  p_nine_bits_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameOk |-> bitCnt == IDX_W'(NBITS));
endmodule

// File: rtl/mpuart_dp.sv
module mpuart_dp
  import mpuart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              filterEn,
  input  logic [DATA_W-1:0] stationAddr,
  input  logic [DATA_W-1:0] addrMask,
  input  logic              intClear,
  input  rxStrobe_t         strb,
  output logic              rxSync,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxNinth,
  output logic              rxIntFlag,
  output logic              overrun
);
  logic [1:0]        syncQ;
  logic [DATA_W:0]   shiftReg;
  logic [DATA_W-1:0] frameData, groupAddr;
  logic              frameNinth, uniHit, groupHit, accept;

  assign rxSync = syncQ[1];

  always_comb begin
    frameData  = shiftReg[DATA_W-1:0];
    frameNinth = shiftReg[DATA_W];
    groupAddr  = stationAddr | addrMask;
    uniHit     = ((frameData ^ stationAddr) & addrMask) == '0;
    groupHit   = (frameData & groupAddr) == groupAddr;
    accept     = strb.frameOk && (!filterEn || (frameNinth && (uniHit || groupHit)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= 2'b11;
      shiftReg  <= '0;
      rxByte    <= '0;
      rxNinth   <= 1'b0;
      rxIntFlag <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rxLine};
      if (strb.shift) shiftReg <= {rxSync, shiftReg[DATA_W:1]};
      if (accept) begin
        rxByte  <= frameData;
        rxNinth <= frameNinth;
      end
      rxIntFlag <= accept || (rxIntFlag && !intClear);
      overrun   <= (accept && rxIntFlag && !intClear) || (overrun && !intClear);
    end
  end

  p_open_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameOk && !filterEn |=> rxIntFlag && rxByte == $past(frameData));
  p_data_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameOk && filterEn && !frameNinth |=> $stable(rxByte) && $stable(rxNinth));
  p_all_ones_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameOk && filterEn && frameNinth && (&frameData) |=> rxIntFlag);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> $stable(rxByte) && $stable(rxNinth));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    intClear && !accept |=> !rxIntFlag && !overrun);
  p_overrun_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxIntFlag));
endmodule

// File: rtl/mpuart_addr_filter.sv
module mpuart_addr_filter
  import mpuart_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int OVS      = 16,
  parameter int TICK_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              filterEn,
  input  logic [DATA_W-1:0] stationAddr,
  input  logic [DATA_W-1:0] addrMask,
  input  logic              intClear,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxNinth,
  output logic              rxIntFlag,
  output logic              overrun
);
  rxStrobe_t strb;
  logic      rxSync;

  mpuart_ctrl #(.DATA_W(DATA_W), .OVS(OVS), .TICK_DIV(TICK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxSync(rxSync), .strb(strb));

  mpuart_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .filterEn(filterEn),
    .stationAddr(stationAddr), .addrMask(addrMask), .intClear(intClear),
    .strb(strb), .rxSync(rxSync), .rxByte(rxByte), .rxNinth(rxNinth),
    .rxIntFlag(rxIntFlag), .overrun(overrun));
endmodule

// File: tb/test_mpuart_addr_filter.sv
module test_mpuart_addr_filter;
  localparam int TICK_DIV = 2;
  localparam int BIT      = 16 * TICK_DIV;
  localparam int NVEC     = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       filterEn = 1'b0;
  logic [7:0] stationAddr = '0;
  logic [7:0] addrMask = '0;
  logic       intClear = 1'b0;
  logic [7:0] rxByte;
  logic       rxNinth, rxIntFlag, overrun;
  int         checks = 0;
  int         fails = 0;
  logic       done = 1'b0;

  always #10 clk = ~clk;

  mpuart_addr_filter #(.TICK_DIV(TICK_DIV)) i_mpuart_addr_filter (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .filterEn(filterEn),
    .stationAddr(stationAddr), .addrMask(addrMask), .intClear(intClear),
    .rxByte(rxByte), .rxNinth(rxNinth), .rxIntFlag(rxIntFlag), .overrun(overrun));

  // {filterEn, addr, mask, data, ninth, stop, expectAccept, tag}
  typedef struct packed {
    logic       fe;
    logic [7:0] addr;
    logic [7:0] mask;
    logic [7:0] data;
    logic       ninth;
    logic       stop;
    logic       acc;
    logic [7:0] req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h35, 8'h0F, 8'hA5, 1'b0, 1'b1, 1'b1, 8'd3},  // R3 data frame, filter off
    '{1'b0, 8'h35, 8'h0F, 8'h12, 1'b1, 1'b1, 1'b1, 8'd3},  // R3 address frame, filter off
    '{1'b1, 8'h35, 8'h0F, 8'hF5, 1'b1, 1'b1, 1'b1, 8'd5},  // R5 masked hit
    '{1'b1, 8'h35, 8'hF3, 8'hF5, 1'b1, 1'b1, 1'b0, 8'd7},  // R7 miss
    '{1'b1, 8'h35, 8'hF3, 8'hFF, 1'b1, 1'b1, 1'b1, 8'd6},  // R6 all ones
    '{1'b1, 8'h35, 8'hC0, 8'hFF, 1'b1, 1'b1, 1'b1, 8'd6},  // R6 all ones
    '{1'b1, 8'h35, 8'hC0, 8'h3A, 1'b1, 1'b1, 1'b1, 8'd5},  // R5 top bits match
    '{1'b1, 8'h35, 8'hC0, 8'h7A, 1'b1, 1'b1, 1'b0, 8'd7},  // R7 miss
    '{1'b1, 8'h35, 8'h0F, 8'hF5, 1'b0, 1'b1, 1'b0, 8'd4},  // R4 data frame filtered
    '{1'b1, 8'h35, 8'hF3, 8'h31, 1'b1, 1'b1, 1'b1, 8'd5},  // R5 don't-care bits differ
    '{1'b0, 8'h35, 8'h0F, 8'h5A, 1'b1, 1'b0, 1'b0, 8'd2},  // R2 bad stop, filter off
    '{1'b1, 8'h35, 8'h0F, 8'hF5, 1'b1, 1'b0, 1'b0, 8'd2},  // R2 bad stop, filter on
    '{1'b1, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 8'd5},  // R5 empty mask
    '{1'b1, 8'h35, 8'h0F, 8'h3F, 1'b1, 1'b1, 1'b1, 8'd6},  // R6 group hit only
    '{1'b1, 8'hAA, 8'h55, 8'hFF, 1'b1, 1'b1, 1'b1, 8'd6},  // R6 group = FF
    '{1'b1, 8'h35, 8'h0F, 8'h06, 1'b1, 1'b1, 1'b0, 8'd7}   // R7 miss both
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic n, input logic s);
    @(negedge clk) rxLine = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = d[i];
      repeat (BIT) @(negedge clk);
    end
    rxLine = n;
    repeat (BIT) @(negedge clk);
    rxLine = s;
    repeat (BIT) @(negedge clk);
    rxLine = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic pulseClear();
    @(negedge clk) intClear = 1'b1;
    @(negedge clk) intClear = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] lastByte;
    logic       lastNinth;
    repeat (3) @(negedge clk);
    check("R11 flag", rxIntFlag, 0);
    check("R11 overrun", overrun, 0);
    check("R11 byte", rxByte, 0);
    check("R11 ninth", rxNinth, 0);
    rstN = 1'b1;
    repeat (BIT) @(negedge clk);
    lastByte = 8'h00;
    lastNinth = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
      filterEn    = VECS[v].fe;
      stationAddr = VECS[v].addr;
      addrMask    = VECS[v].mask;
      repeat (BIT) @(negedge clk);
      sendFrame(VECS[v].data, VECS[v].ninth, VECS[v].stop);
      check(tag, rxIntFlag, VECS[v].acc);
      if (VECS[v].acc) begin
        lastByte  = VECS[v].data;
        lastNinth = VECS[v].ninth;
      end
      check({tag, " byte (R8 when dropped)"}, rxByte, lastByte);
      check({tag, " ninth"}, rxNinth, lastNinth);
      check({tag, " overrun"}, overrun, 0);
      pulseClear();
      check("R9 flag cleared", rxIntFlag, 0);
    end

    // R1: short low glitch starts no frame; next frame still received
    filterEn = 1'b0;
    @(negedge clk) rxLine = 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk);
    rxLine = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    check("R1 glitch ignored", rxIntFlag, 0);
    sendFrame(8'h96, 1'b0, 1'b1);
    check("R1 frame after glitch flag", rxIntFlag, 1);
    check("R1 LSB-first byte", rxByte, 8'h96);

    // R9: flag is sticky over idle time
    repeat (4 * BIT) @(negedge clk);
    check("R9 flag sticky", rxIntFlag, 1);
    check("R9 no overrun yet", overrun, 0);

    // R10: second accepted frame without a clear
    sendFrame(8'h3C, 1'b1, 1'b1);
    check("R10 overrun set", overrun, 1);
    check("R10 byte overwritten", rxByte, 8'h3C);
    check("R10 ninth overwritten", rxNinth, 1);
    pulseClear();
    check("R9 clear flag", rxIntFlag, 0);
    check("R9 clear overrun", overrun, 0);

    // R4: filtered data frame leaves the flag low with filter on
    filterEn = 1'b1;
    stationAddr = 8'h35;
    addrMask = 8'h0F;
    repeat (BIT) @(negedge clk);
    sendFrame(8'h35, 1'b0, 1'b1);
    check("R4 matching byte with ninth 0", rxIntFlag, 0);
    check("R8 byte held", rxByte, 8'h3C);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule